// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a SIMD integer datapath that adds short dot products into a packed vector of 32-bit accumulators. It takes three vectors of the same width: an accumulator, a first operand and a second operand. Each 32-bit lane of the result is that lane's accumulator plus the sum of the products taken from the matching slice of the two operands.

There are two element formats. In the byte format, an unsigned byte is multiplied by a signed byte, and four such products fall in each lane. In the word format, a signed 16-bit word is multiplied by a signed 16-bit word, and two such products fall in each lane. The sum into the lane either wraps or is clamped to the signed 32-bit range. A mask bit for each lane decides whether the lane takes the new sum. A lane whose bit is clear either keeps its accumulator or is cleared, depending on the masking mode. The vector can run at its full width of eight lanes or at half width, which uses four lanes.

The result is registered, so it appears one clock after the request. A companion valid output marks it.

Top module: `dpacc_unit`

## Requirements
- R1: When `opWord`=0 (byte format), lane j adds to its accumulator the four products of byte 4j+k of `opA` and byte 4j+k of `opB`, for k = 0..3. The `opA` byte is taken as unsigned 0..255 and the `opB` byte as signed -128..127. For example, 255 × -128 gives -32640.
- R2: When `opWord`=1 (word format), lane j adds to its accumulator the two products of word 2j+k of `opA` and word 2j+k of `opB`, for k = 0..1. Both words are taken as signed 16-bit values.
- R3: When `opSat`=0, the lane result is the exact sum of the accumulator and the products, reduced modulo 2^32. In word format, two products of -32768 × -32768 on a zero accumulator give 0x80000000.
- R4: When `opSat`=1, the exact sum is formed at full precision with no clamping of partial sums. A sum above 2^31-1 gives 0x7FFFFFFF. The word-format corner case in R3 gives 0x7FFFFFFF in this mode.
- R5: When `opSat`=1, an exact sum below -2^31 gives 0x80000000, and every saturated result keeps the sign of the exact sum.
- R6: When `wideMode`=0 (128-bit), only lanes 0..3 are computed and `maskBits[7:4]` has no effect. Result bits 255:128 are zero. When `wideMode`=1, all eight lanes are active.
- R7: When an active lane's `maskBits` bit is 0 and `zeroMask`=0 (merge), that lane of the result equals its accumulator lane unchanged.
- R8: When an active lane's `maskBits` bit is 0 and `zeroMask`=1 (zeroing), that lane of the result is zero. A lane whose mask bit is 1 takes the computed value in either mode.
- R9: `outValid` is `inValid` delayed by exactly one clock. The result of a request is visible in the cycle after the clock edge that samples `inValid`=1.
- R10: Synchronous reset `rst` clears `result` and `outValid`. While `inValid`=0, `result` holds its last value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe; operands and controls are sampled when high |
| opWord | input | 1 | Element format: 0 = unsigned×signed bytes, 1 = signed words |
| opSat | input | 1 | 1 = clamp to signed 32-bit, 0 = wrap |
| wideMode | input | 1 | 1 = 256-bit (8 lanes), 0 = 128-bit (4 lanes) |
| zeroMask | input | 1 | Treatment of masked-off lanes: 1 = zero, 0 = keep accumulator |
| maskBits | input | 8 | Per-lane write enable, bit j for lane j |
| accIn | input | 256 | Packed 32-bit accumulator lanes |
| opA | input | 256 | First operand (unsigned bytes or signed words) |
| opB | input | 256 | Second operand (signed bytes or signed words) |
| outValid | output | 1 | Result valid, one clock after `inValid` |
| result | output | 256 | Packed 32-bit result lanes |

## Verification
The bench pushes every lane to its arithmetic extremes in both formats. It uses all-0xFF bytes against all-0x80 or all-0x7F bytes, and all-0x8000 words on zero, maximum and minimum accumulators. A design that sign-extends the unsigned byte would give small or wrong-signed sums. A design that clamps partial sums, or keeps too few bits, would show up on the 2^31 word case and on the 0x7FFFFFFF / 0x80000000 accumulators, either wrapping where it should clamp or clamping where it should wrap. Every format, saturation, width and masking combination is swept with directed and random masks. This shows whether masked lanes keep or clear correctly, whether the upper mask nibble leaks in at half width, and whether stale upper bits remain. The bench also changes the data inputs while the unit is idle, to expose a result register that does not hold.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;
  localparam int LANE_W    = 32;
  localparam int NUM_LANES = 8;
  localparam int VEC_W     = LANE_W * NUM_LANES;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 fmtWord;
    logic                 saturate;
    logic                 zeroFill;
    logic                 wide;
    logic [NUM_LANES-1:0] laneActive;
    logic [NUM_LANES-1:0] laneWrite;
  } dpStrobe_t;
endpackage

// File: rtl/dpacc_lane.sv
module dpacc_lane
  import dpacc_pkg::*;
(
  input  logic [LANE_W-1:0] accLane,
  input  logic [LANE_W-1:0] aLane,
  input  logic [LANE_W-1:0] bLane,
  input  logic              fmtWord,
  input  logic              saturate,
  output logic [LANE_W-1:0] laneRes,
  output logic [LANE_W+1:0] fullSum
);
  localparam int SUM_W  = LANE_W + 2;
  localparam int BYTES  = LANE_W / 8;
  localparam int WORDS  = LANE_W / 16;
  localparam logic signed [SUM_W-1:0] SAT_MAX = SUM_W'(64'sd2147483647);
  localparam logic signed [SUM_W-1:0] SAT_MIN = SUM_W'(-64'sd2147483648);

  logic signed [15:0]      byteProd [BYTES];
  logic signed [LANE_W-1:0] wordProd [WORDS];

  // Unsigned byte times signed byte, fits 16 bits signed
  for (genvar k = 0; k < BYTES; k++) begin : g_bprod
    assign byteProd[k] = $signed({8'h00, aLane[8*k +: 8]}) *
                         $signed({{8{bLane[8*k+7]}}, bLane[8*k +: 8]});
  end

  // Signed word times signed word
  for (genvar k = 0; k < WORDS; k++) begin : g_wprod
    assign wordProd[k] = LANE_W'($signed(aLane[16*k +: 16]) * $signed(bLane[16*k +: 16]));
  end

  logic signed [SUM_W-1:0] prodSum;
  always_comb begin
    prodSum = '0;
    if (fmtWord) begin
      for (int k = 0; k < WORDS; k++)
        prodSum = prodSum + SUM_W'(wordProd[k]);
    end else begin
      for (int k = 0; k < BYTES; k++)
        prodSum = prodSum + SUM_W'(byteProd[k]);
    end
  end

  logic signed [SUM_W-1:0] exactSum;
  assign exactSum = $signed({{2{accLane[LANE_W-1]}}, accLane}) + prodSum;
  assign fullSum  = exactSum;

  always_comb begin
    if (saturate && (exactSum > SAT_MAX))      laneRes = SAT_MAX[LANE_W-1:0];
    else if (saturate && (exactSum < SAT_MIN)) laneRes = SAT_MIN[LANE_W-1:0];
    else                                       laneRes = exactSum[LANE_W-1:0];
  end
endmodule

// File: rtl/dpacc_ctrl.sv
module dpacc_ctrl
  import dpacc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 opWord,
  input  logic                 opSat,
  input  logic                 wideMode,
  input  logic                 zeroMask,
  input  logic [NUM_LANES-1:0] maskBits,
  output dpStrobe_t            strb,
  output logic                 outValid
);
  localparam int HALF_LANES = NUM_LANES / 2;

  logic [NUM_LANES-1:0] activeVec;
  for (genvar j = 0; j < NUM_LANES; j++) begin : g_active
    if (j < HALF_LANES) begin : g_low
      assign activeVec[j] = 1'b1;
    end else begin : g_high
      assign activeVec[j] = wideMode;
    end
  end

  always_comb begin
    strb.load       = inValid;
    strb.fmtWord    = opWord;
    strb.saturate   = opSat;
    strb.zeroFill   = zeroMask;
    strb.wide       = wideMode;
    strb.laneActive = activeVec;
    strb.laneWrite  = activeVec & maskBits;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R9
endmodule

// File: rtl/dpacc_datapath.sv
module dpacc_datapath
  import dpacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic [VEC_W-1:0] accIn,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] resultQ
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0]  nextVec;
  logic [LANE_W+1:0] laneFull [NUM_LANES];

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic [LANE_W-1:0] laneRes;

    dpacc_lane u_lane (
      .accLane  (accIn[j*LANE_W +: LANE_W]),
      .aLane    (opA[j*LANE_W +: LANE_W]),
      .bLane    (opB[j*LANE_W +: LANE_W]),
      .fmtWord  (strb.fmtWord),
      .saturate (strb.saturate),
      .laneRes  (laneRes),
      .fullSum  (laneFull[j])
    );

    always_comb begin
      if (!strb.laneActive[j])    nextVec[j*LANE_W +: LANE_W] = '0;
      else if (strb.laneWrite[j]) nextVec[j*LANE_W +: LANE_W] = laneRes;
      else if (strb.zeroFill)     nextVec[j*LANE_W +: LANE_W] = '0;
      else                        nextVec[j*LANE_W +: LANE_W] = accIn[j*LANE_W +: LANE_W];
    end

    AST_MERGE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
      (strb.load && strb.laneActive[j] && !strb.laneWrite[j] && !strb.zeroFill)
      |=> resultQ[j*LANE_W +: LANE_W] == $past(accIn[j*LANE_W +: LANE_W])); // R7
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (strb.load && !strb.laneWrite[j] && strb.zeroFill)
      |=> resultQ[j*LANE_W +: LANE_W] == '0); // R8
    AST_SAT_SIGN: assert property (@(posedge clk) disable iff (rst)
      (strb.load && strb.saturate && strb.laneWrite[j])
      |=> resultQ[j*LANE_W + LANE_W-1] == $past(laneFull[j][LANE_W+1])); // R5
  end

  always_ff @(posedge clk) begin
    if (rst)            resultQ <= '0;
    else if (strb.load) resultQ <= nextVec;
  end

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !strb.wide) |=> resultQ[VEC_W-1:HALF_W] == '0); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(resultQ)); // R10
endmodule

// File: rtl/dpacc_unit.sv
module dpacc_unit
  import dpacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             opWord,
  input  logic             opSat,
  input  logic             wideMode,
  input  logic             zeroMask,
  input  logic [7:0]       maskBits,
  input  logic [255:0]     accIn,
  input  logic [255:0]     opA,
  input  logic [255:0]     opB,
  output logic             outValid,
  output logic [255:0]     result
);
  dpStrobe_t strb;

  dpacc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opWord   (opWord),
    .opSat    (opSat),
    .wideMode (wideMode),
    .zeroMask (zeroMask),
    .maskBits (maskBits),
    .strb     (strb),
    .outValid (outValid)
  );

  dpacc_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .accIn   (accIn),
    .opA     (opA),
    .opB     (opB),
    .resultQ (result)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0)); // R10
endmodule

// File: tb/tb_dpacc_unit.sv
module tb_dpacc_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid, opWord, opSat, wideMode, zeroMask;
  logic [7:0]   maskBits;
  logic [255:0] accIn, opA, opB;
  logic         outValid;
  logic [255:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dpacc_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opWord(opWord), .opSat(opSat),
    .wideMode(wideMode), .zeroMask(zeroMask), .maskBits(maskBits),
    .accIn(accIn), .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refLane(input logic [31:0] acc, input logic [31:0] a,
                                          input logic [31:0] b, input logic word,
                                          input logic sat);
    longint s;
    s = longint'($signed(acc));
    if (word) begin
      for (int k = 0; k < 2; k++)
        s += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
    end else begin
      for (int k = 0; k < 4; k++)
        s += longint'(a[8*k +: 8]) * longint'($signed(b[8*k +: 8]));
    end
    if (sat && s > 64'sd2147483647)  s = 64'sd2147483647;
    if (sat && s < -64'sd2147483648) s = -64'sd2147483648;
    return s[31:0];
  endfunction

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic runOne(input logic w, input logic s, input logic wd, input logic z,
                        input logic [7:0] m, input logic [255:0] acc,
                        input logic [255:0] a, input logic [255:0] b);
    logic [255:0] held;
    logic [31:0]  expL;
    string        tag;
    @(negedge clk);
    inValid = 1'b1; opWord = w; opSat = s; wideMode = wd; zeroMask = z;
    maskBits = m; accIn = acc; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    accIn = rnd256(); opA = rnd256(); opB = rnd256(); maskBits = 8'($urandom);
    check("R9 outValid after request", {255'd0, outValid}, 256'd1);
    for (int j = 0; j < 8; j++) begin
      if (!wd && j >= 4) begin
        expL = '0; tag = "R6 inactive lane";
      end else if (m[j]) begin
        expL = refLane(acc[32*j +: 32], a[32*j +: 32], b[32*j +: 32], w, s);
        if (s)      tag = w ? "R2 R4 R5" : "R1 R4 R5";
        else        tag = w ? "R2 R3" : "R1 R3";
      end else if (z) begin
        expL = '0; tag = "R8 zero mask";
      end else begin
        expL = acc[32*j +: 32]; tag = "R7 merge mask";
      end
      check(tag, {224'd0, result[32*j +: 32]}, {224'd0, expL});
    end
    held = result;
    @(negedge clk);
    check("R9 outValid drops", {255'd0, outValid}, 256'd0);
    check("R10 hold while idle", result, held);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; opWord = 0; opSat = 0; wideMode = 0; zeroMask = 0;
    maskBits = '0; accIn = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    check("R10 reset outValid", {255'd0, outValid}, 256'd0);
    check("R10 reset result", result, 256'd0);
    rst = 1'b0;

    for (int v = 0; v < 4; v++)
      for (int wd = 0; wd < 2; wd++)
        for (int z = 0; z < 2; z++)
          for (int p = 0; p < 10; p++) begin
            logic [255:0] acc, a, b;
            logic [7:0]   m;
            case (p)
              0: begin acc = '0; a = {256{1'b1}}; b = {32{8'h80}}; end
              1: begin acc = '0; a = {256{1'b1}}; b = {32{8'h7f}}; end
              2: begin acc = '0; a = {16{16'h8000}}; b = {16{16'h8000}}; end
              3: begin acc = {8{32'h7fffffff}}; a = {256{1'b1}}; b = {16{16'h7fff}}; end
              4: begin acc = {8{32'h80000000}}; a = {256{1'b1}}; b = {32{8'h80}}; end
              5: begin acc = {8{32'h80000000}}; a = {16{16'h8000}}; b = {16{16'h7fff}}; end
              default: begin acc = rnd256(); a = rnd256(); b = rnd256(); end
            endcase
            if (p % 3 == 0)      m = 8'hff;
            else if (p == 4)     m = 8'hf0;
            else                 m = 8'($urandom);
            runOne(v[1], v[0], wd[0], z[0], m, acc, a, b);
          end

    // explicit corner: word 2^31 wraps / clamps
    runOne(1'b1, 1'b0, 1'b1, 1'b0, 8'hff, '0, {16{16'h8000}}, {16{16'h8000}});
    check("R3 word corner wraps", {224'd0, result[31:0]}, {224'd0, 32'h80000000});
    runOne(1'b1, 1'b1, 1'b1, 1'b0, 8'hff, '0, {16{16'h8000}}, {16{16'h8000}});
    check("R4 word corner clamps", {224'd0, result[31:0]}, {224'd0, 32'h7fffffff});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule